// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the byte-wide arithmetic and logic stage of a small controller core. It holds the accumulator, the carry flag and the auxiliary-carry flag in registers. Each clock cycle it takes one operation code and one second operand, which may be a register byte, a memory byte or an immediate byte. The result and the new flags are written back on the same rising edge. Fetching the operand, decoding instructions and sequencing the program are left to the surrounding core.

The operations are:

- binary add, with or without the incoming carry;
- the bitwise logic operations;
- increment and decrement;
- clear and complement;
- single-position rotates, either plain or through the carry;
- exchange of the two nibbles;
- decimal correction after a packed-BCD addition;
- load of the accumulator, and direct writes or edits of the carry.

Only the two adds, decimal correction, the through-carry rotates and the explicit flag operations alter any flag. The flags appear to the outside as a status byte at fixed bit positions.

The single "state" of the block is the register set {accumulator, carry, auxiliary carry}. There is one transition per operation code, listed in the requirements. Reset returns the block to the cleared state.

Top module: `acc_alu_unit`

## Requirements
- R1: While `rst_n` is low (asynchronous), `acc_q` is 00h and `flags_q` is 00h.
- R2: ADD (code 2) and ADDC (code 3) set the accumulator to (acc + operand + cin) mod 256. Here cin is the carry for ADDC and 0 for ADD. Carry becomes the carry out of bit 7, and the auxiliary carry becomes the carry out of bit 3, with cin included.
- R3: AND (4), OR (5), XOR (6), INC (7), DEC (8), CLR (9) and CPL (10) produce acc&op, acc|op, acc^op, acc+1, acc-1, 00h and ~acc. Increment wraps FFh to 00h and decrement wraps 00h to FFh. Both flags are left unchanged.
- R4: RL (11) rotates the accumulator left by one and RR (12) rotates it right by one. Carry and auxiliary carry are unchanged.
- R5: RLC (13) rotates left through a 9-bit ring: bit 7 goes to carry and the old carry goes to bit 0. RRC (14) does the reverse: bit 0 goes to carry and the old carry goes to bit 7. The auxiliary carry is unchanged.
- R6: SWAP (15) exchanges accumulator bits 7:4 with bits 3:0. The flags are unchanged.
- R7: CLRC (17) clears the carry and CPLC (18) inverts it. The accumulator and auxiliary carry are unchanged.
- R8: DA (16) first adds 06h when the low nibble is greater than 9 or the auxiliary carry is set. It then adds 60h when the high nibble of that result is greater than 9, the carry is set, or the first step overflowed. Carry becomes old carry OR either overflow. The auxiliary carry is unchanged.
- R9: LOAD (1) copies the operand into the accumulator and leaves the flags unchanged. SETFL (19) sets carry to operand bit 7 and the auxiliary carry to operand bit 6, and leaves the accumulator unchanged.
- R10: NOP (0) and the unused codes 20 to 31 change neither the accumulator nor the flags.
- R11: `flags_q` bit 7 is the carry, bit 6 is the auxiliary carry, and bits 5:0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 5 | Operation code for this cycle |
| operand | input | 8 | Second operand byte |
| acc_q | output | 8 | Registered accumulator |
| flags_q | output | 8 | Status byte: carry at bit 7, auxiliary carry at bit 6 |

## Verification
ADDC, RLC, RRC, DA and CPLC read the carry and write it back in the same cycle. A fault in how the carry is read back, such as using the newly computed carry in place of the registered one, shows up only when such operations run back to back. The random stream is weighted so that carry consumers often directly follow carry producers. Directed sequences add to this: an overflowing ADD followed by ADDC, and a BCD add followed by DA. Each step is judged against a bench model that advances from the flags it held after the previous step.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 5;
    localparam int CY_POS = 7;
    localparam int AC_POS = 6;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 5'd0,
        OP_LOAD  = 5'd1,
        OP_ADD   = 5'd2,
        OP_ADDC  = 5'd3,
        OP_AND   = 5'd4,
        OP_OR    = 5'd5,
        OP_XOR   = 5'd6,
        OP_INC   = 5'd7,
        OP_DEC   = 5'd8,
        OP_CLR   = 5'd9,
        OP_CPL   = 5'd10,
        OP_RL    = 5'd11,
        OP_RR    = 5'd12,
        OP_RLC   = 5'd13,
        OP_RRC   = 5'd14,
        OP_SWAP  = 5'd15,
        OP_DA    = 5'd16,
        OP_CLRC  = 5'd17,
        OP_CPLC  = 5'd18,
        OP_SETFL = 5'd19
    } alu_op_e;

    typedef enum logic [1:0] {
        ROT_L  = 2'd0,
        ROT_R  = 2'd1,
        ROT_LC = 2'd2,
        ROT_RC = 2'd3
    } rot_mode_e;
endpackage

// File: rtl/acc_alu_adder.sv
`timescale 1ns/1ps
module acc_alu_adder
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int H = NIB_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         half_cout
);
    localparam int HW = W - H;

    logic [H:0]  lo_sum;
    logic [HW:0] hi_sum;

    always_comb begin
        lo_sum    = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
        hi_sum    = {1'b0, a[W-1:H]} + {1'b0, b[W-1:H]} + {{HW{1'b0}}, lo_sum[H]};
        sum       = {hi_sum[HW-1:0], lo_sum[H-1:0]};
        cout      = hi_sum[HW];
        half_cout = lo_sum[H];
    end
endmodule

// File: rtl/acc_alu_rotor.sv
`timescale 1ns/1ps
module acc_alu_rotor
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  rot_mode_e    mode,
    input  logic [W-1:0] din,
    input  logic         cin,
    output logic [W-1:0] dout,
    output logic         cout
);
    always_comb begin
        unique case (mode)
            ROT_L: begin
                dout = {din[W-2:0], din[W-1]};
                cout = cin;
            end
            ROT_R: begin
                dout = {din[0], din[W-1:1]};
                cout = cin;
            end
            ROT_LC: begin
                dout = {din[W-2:0], cin};
                cout = din[W-1];
            end
            default: begin
                dout = {cin, din[W-1:1]};
                cout = din[0];
            end
        endcase
    end
endmodule

// File: rtl/acc_alu_decadj.sv
`timescale 1ns/1ps
module acc_alu_decadj
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int H = NIB_W
) (
    input  logic [W-1:0] din,
    input  logic         cy_in,
    input  logic         ac_in,
    output logic [W-1:0] dout,
    output logic         cy_out
);
    localparam int          HW     = W - H;
    localparam logic [W:0]  LO_SIX = (W+1)'(6);
    localparam logic [W:0]  HI_SIX = (W+1)'(6 << H);
    localparam logic [H-1:0]  LO_NINE = H'(9);
    localparam logic [HW-1:0] HI_NINE = HW'(9);

    logic       lo_fix;
    logic       hi_fix;
    logic [W:0] step1;
    logic [W:0] step2;

    always_comb begin
        lo_fix = (din[H-1:0] > LO_NINE) || ac_in;
        step1  = {1'b0, din} + (lo_fix ? LO_SIX : '0);
        hi_fix = (step1[W-1:H] > HI_NINE) || cy_in || step1[W];
        step2  = {1'b0, step1[W-1:0]} + (hi_fix ? HI_SIX : '0);
        dout   = step2[W-1:0];
        cy_out = cy_in | step1[W] | step2[W];
    end
endmodule

// File: rtl/acc_alu_unit.sv
`timescale 1ns/1ps
module acc_alu_unit
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc_q,
    output logic [DATA_W-1:0] flags_q
);
    alu_op_e           cur_op;
    logic              cy_r;
    logic              ac_r;
    logic [DATA_W-1:0] acc_nxt;
    logic              cy_nxt;
    logic              ac_nxt;

    logic [DATA_W-1:0] add_sum;
    logic              add_cout;
    logic              add_hcout;
    logic              add_cin;

    rot_mode_e         rot_mode;
    logic [DATA_W-1:0] rot_out;
    logic              rot_cy;

    logic [DATA_W-1:0] da_out;
    logic              da_cy;

    assign cur_op  = alu_op_e'(op_sel);
    assign add_cin = (cur_op == OP_ADDC) ? cy_r : 1'b0;

    acc_alu_adder #(.W(DATA_W), .H(NIB_W)) u_adder (
        .a         (acc_q),
        .b         (operand),
        .cin       (add_cin),
        .sum       (add_sum),
        .cout      (add_cout),
        .half_cout (add_hcout)
    );

    always_comb begin
        unique case (cur_op)
            OP_RR:   rot_mode = ROT_R;
            OP_RLC:  rot_mode = ROT_LC;
            OP_RRC:  rot_mode = ROT_RC;
            default: rot_mode = ROT_L;
        endcase
    end

    acc_alu_rotor #(.W(DATA_W)) u_rotor (
        .mode (rot_mode),
        .din  (acc_q),
        .cin  (cy_r),
        .dout (rot_out),
        .cout (rot_cy)
    );

    acc_alu_decadj #(.W(DATA_W), .H(NIB_W)) u_decadj (
        .din    (acc_q),
        .cy_in  (cy_r),
        .ac_in  (ac_r),
        .dout   (da_out),
        .cy_out (da_cy)
    );

    // next-state selection, one transition per operation code
    always_comb begin
        acc_nxt = acc_q;
        cy_nxt  = cy_r;
        ac_nxt  = ac_r;
        unique case (cur_op)
            OP_LOAD:  acc_nxt = operand;
            OP_ADD, OP_ADDC: begin
                acc_nxt = add_sum;
                cy_nxt  = add_cout;
                ac_nxt  = add_hcout;
            end
            OP_AND:   acc_nxt = acc_q & operand;
            OP_OR:    acc_nxt = acc_q | operand;
            OP_XOR:   acc_nxt = acc_q ^ operand;
            OP_INC:   acc_nxt = acc_q + DATA_W'(1);
            OP_DEC:   acc_nxt = acc_q - DATA_W'(1);
            OP_CLR:   acc_nxt = '0;
            OP_CPL:   acc_nxt = ~acc_q;
            OP_RL, OP_RR, OP_RLC, OP_RRC: begin
                acc_nxt = rot_out;
                cy_nxt  = rot_cy;
            end
            OP_SWAP:  acc_nxt = {acc_q[NIB_W-1:0], acc_q[DATA_W-1:NIB_W]};
            OP_DA: begin
                acc_nxt = da_out;
                cy_nxt  = da_cy;
            end
            OP_CLRC:  cy_nxt = 1'b0;
            OP_CPLC:  cy_nxt = ~cy_r;
            OP_SETFL: begin
                cy_nxt = operand[CY_POS];
                ac_nxt = operand[AC_POS];
            end
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cy_r  <= 1'b0;
            ac_r  <= 1'b0;
        end else begin
            acc_q <= acc_nxt;
            cy_r  <= cy_nxt;
            ac_r  <= ac_nxt;
        end
    end

    // status byte with fixed flag positions
    always_comb begin
        flags_q         = '0;
        flags_q[CY_POS] = cy_r;
        flags_q[AC_POS] = ac_r;
    end

    a_r3_logic_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_op inside {OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_CLR, OP_CPL})
        |=> (cy_r == $past(cy_r)) && (ac_r == $past(ac_r)));

    a_r4_plain_rotate_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_op inside {OP_RL, OP_RR}) |=> (cy_r == $past(cy_r)));

    a_r5_ring_left: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_op == OP_RLC) |=> (cy_r == $past(acc_q[DATA_W-1])) && (acc_q[0] == $past(cy_r)));

    a_r6_swap_halves: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_op == OP_SWAP)
        |=> (acc_q == {$past(acc_q[NIB_W-1:0]), $past(acc_q[DATA_W-1:NIB_W])}));

    a_r7_clear_carry_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_op == OP_CLRC) |=> !cy_r && (acc_q == $past(acc_q)) && (ac_r == $past(ac_r)));

    a_r11_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[AC_POS-1:0] == '0);
endmodule

// File: tb/acc_alu_unit_test.sv
`timescale 1ns/1ps
module acc_alu_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_sel = 5'd0;
    logic [7:0] operand = 8'd0;
    logic [7:0] acc_q;
    logic [7:0] flags_q;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_acc = 8'd0;
    logic       m_cy = 1'b0;
    logic       m_ac = 1'b0;

    always #10 clk = ~clk;

    acc_alu_unit uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_sel  (op_sel),
        .operand (operand),
        .acc_q   (acc_q),
        .flags_q (flags_q)
    );

    function automatic string tag_of(input int op);
        case (op)
            2, 3:                 return "R2";
            4, 5, 6, 7, 8, 9, 10: return "R3";
            11, 12:               return "R4";
            13, 14:               return "R5";
            15:                   return "R6";
            16:                   return "R8";
            17, 18:               return "R7";
            1, 19:                return "R9";
            default:              return "R10";
        endcase
    endfunction

    function automatic logic [9:0] model(input int op, input logic [7:0] a, input logic [7:0] b,
                                         input logic cy, input logic ac);
        int s;
        int ci;
        logic [7:0] r;
        logic c;
        logic x;
        r = a; c = cy; x = ac;
        ci = (op == 3) ? int'(cy) : 0;
        case (op)
            1: r = b;
            2, 3: begin
                s = int'(a) + int'(b) + ci;
                r = s[7:0];
                c = (s > 255);
                x = ((int'(a) % 16) + (int'(b) % 16) + ci) > 15;
            end
            4: r = a & b;
            5: r = a | b;
            6: r = a ^ b;
            7: r = a + 8'd1;
            8: r = a - 8'd1;
            9: r = 8'd0;
            10: r = ~a;
            11: r = {a[6:0], a[7]};
            12: r = {a[0], a[7:1]};
            13: begin r = {a[6:0], cy}; c = a[7]; end
            14: begin r = {cy, a[7:1]}; c = a[0]; end
            15: r = {a[3:0], a[7:4]};
            16: begin
                s = int'(a);
                if ((s % 16) > 9 || ac) s = s + 6;
                if (((s / 16) % 16) > 9 || cy || s > 255) s = s + 96;
                r = s[7:0];
                c = cy || (s > 255);
            end
            17: c = 1'b0;
            18: c = ~cy;
            19: begin c = b[7]; x = b[6]; end
            default: ;
        endcase
        return {r, c, x};
    endfunction

    task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge after the result register updates
    task automatic run_op(input int op, input logic [7:0] b);
        logic [9:0] e;
        string t;
        e = model(op, m_acc, b, m_cy, m_ac);
        t = tag_of(op);
        op_sel = 5'(op);
        operand = b;
        @(negedge clk);
        check8(t, "accumulator", acc_q, e[9:2]);
        check8({t, "/R11"}, "flags", flags_q, {e[1], e[0], 6'b0});
        m_acc = e[9:2];
        m_cy = e[1];
        m_ac = e[0];
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op_sel = 5'd2;
        operand = 8'hFF;
        repeat (2) @(negedge clk);
        check8("R1", "acc in reset", acc_q, 8'h00);
        check8("R1", "flags in reset", flags_q, 8'h00);
        m_acc = 8'd0; m_cy = 1'b0; m_ac = 1'b0;
        op_sel = 5'd0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd7301);
        @(negedge clk);
        do_reset();

        // R2 / R8: BCD 19 + 28 then decimal adjust gives 47
        run_op(1, 8'h19);
        run_op(2, 8'h28);
        run_op(16, 8'h00);
        // R2 carry out, then ADDC consumes it
        run_op(1, 8'hFF);
        run_op(2, 8'h01);
        run_op(3, 8'h0F);
        // R8 with both adjustments: 99 + 99
        run_op(1, 8'h99);
        run_op(2, 8'h99);
        run_op(16, 8'h00);
        // R3 wraps
        run_op(1, 8'h00);
        run_op(8, 8'h00);
        run_op(7, 8'h00);
        run_op(7, 8'h00);
        // R9 flag write, R5 ring, R4 plain rotate
        run_op(19, 8'hC0);
        run_op(1, 8'h81);
        run_op(13, 8'h00);
        run_op(14, 8'h00);
        run_op(11, 8'h00);
        run_op(12, 8'h00);
        // R6, R7
        run_op(15, 8'h00);
        run_op(18, 8'h00);
        run_op(17, 8'h00);
        // R10 unused codes
        run_op(25, 8'hAA);
        run_op(31, 8'h55);
        run_op(0, 8'h12);

        for (int i = 0; i < 4000; i++) begin
            int op;
            int pick;
            pick = int'($urandom_range(0, 99));
            if (pick < 70) op = int'($urandom_range(1, 19));
            else if (pick < 90) op = (pick % 2 == 0) ? 3 : 16;
            else op = int'($urandom_range(20, 31));
            run_op(op, 8'($urandom));
            if (i == 2000) do_reset();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule